// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a small synchronous SRAM. It takes one read or write command on every rising clock edge and can switch between reads and writes with no idle cycles. Read data appears two edges after its command. Write data is sampled two edges after its command, so both directions use the same pipeline slot and the shared data bus never needs a turnaround cycle.

A command is either a load or an advance. A load takes a new address and a new operation, provided all three chip enables are active. An advance repeats the previous operation at the next address of a four-beat burst. The burst walks through the two low address bits in linear or interleaved order. Writes are masked per 9-bit byte. A clock enable stalls the whole pipeline, including the output register. The bidirectional data bus is split into a data input, a data output and a drive enable. The drive enable is gated by an asynchronous output enable.

Top module: `pipe_sram`

## Requirements
- R1: A read loaded at rising edge N puts the word from its address on `data_out` after edge N+2, and `data_oe` is high from then until edge N+3 while `oe` is high.
- R2: Reads and writes can be issued in any order on consecutive edges with no wait state. The write data for a write loaded at edge N is sampled from `data_in` at edge N+2.
- R3: An edge with `clk_en` low is ignored. The burst state, the pipeline, `data_out` and `data_oe` keep their values, and data that belongs to a stalled write is sampled at the next enabled edge.
- R4: A write updates only the bytes whose `byte_sel` bit is 1. Bit i covers `data_in` bits [9i+8:9i].
- R5: A load selects the device only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A deselected command writes nothing, and `data_oe` stays low in the slot where its data would be.
- R6: `data_oe` is low at once whenever `oe` is low. It is also low during the data slot of a write.
- R7: With `burst_lin`=1 at the load, beat k (0 for the load, then 1,2,3 for the advances) uses address low bits (base+k) mod 4. The upper address bits stay fixed.
- R8: With `burst_lin`=0 at the load, beat k uses address low bits base XOR k.
- R9: An advance that follows a deselected load stays deselected.
- R10: A read issued on the edge right after a write to the same address returns the newly written, byte-merged word.
- R11: After reset, `data_out` is 0 and `data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Edge qualifier; low stalls the block |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = advance the burst, 0 = load a new command |
| wr_en | input | 1 | Operation of a load: 1 write, 0 read |
| byte_sel | input | NBYTES | Per-byte write mask, sampled with each command |
| addr | input | ADDR_W | Word address of a load |
| burst_lin | input | 1 | Burst order at a load: 1 linear, 0 interleaved |
| oe | input | 1 | Asynchronous output enable |
| data_in | input | NBYTES*BYTE_W | Write data, sampled two edges after the command |
| data_out | output | NBYTES*BYTE_W | Registered read data |
| data_oe | output | 1 | Drive enable for the bus |

## Verification
The hardest case to reach is a stall that falls between a write command and its data slot. The data that belongs to the write must then be sampled at a later edge than usual, while a read to the same address is already queued behind it. The bench creates this case on purpose. It issues write, read and write to one address, and then pulls `clk_en` low for several edges while data that does not belong to the write sits on `data_in`. A long random run adds further stalls, deselects and bursts in both orders, and every output is compared against a reference array after each edge.

// File: rtl/pipe_sram.sv
module pipe_sram #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              adv,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] byte_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_lin,
  input  logic              oe,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);

  logic [DATA_W-1:0] mem [DEPTH];

  logic              b_act, b_wr, b_lin;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt;

  logic              s1_v, s1_wr, s2_v, s2_wr;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [NBYTES-1:0] s1_m, s2_m;
  logic              oe_r;

  wire               selected = !ce_a_n && ce_b && !ce_c_n;
  wire               n_act    = adv ? b_act  : selected;
  wire               n_wr     = adv ? b_wr   : wr_en;
  wire               n_lin    = adv ? b_lin  : burst_lin;
  wire [ADDR_W-1:0]  n_base   = adv ? b_base : addr;
  wire [1:0]         n_cnt    = adv ? b_cnt + 2'd1 : 2'd0;
  wire [1:0]         n_low    = n_lin ? n_base[1:0] + n_cnt : n_base[1:0] ^ n_cnt;
  wire [ADDR_W-1:0]  n_addr   = {n_base[ADDR_W-1:2], n_low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act    <= 1'b0;
      b_wr     <= 1'b0;
      b_lin    <= 1'b0;
      b_base   <= '0;
      b_cnt    <= '0;
      s1_v     <= 1'b0;
      s1_wr    <= 1'b0;
      s1_a     <= '0;
      s1_m     <= '0;
      s2_v     <= 1'b0;
      s2_wr    <= 1'b0;
      s2_a     <= '0;
      s2_m     <= '0;
      oe_r     <= 1'b0;
      data_out <= '0;
    end else if (clk_en) begin
      b_act  <= n_act;
      b_wr   <= n_wr;
      b_lin  <= n_lin;
      b_base <= n_base;
      b_cnt  <= n_cnt;
      s1_v   <= n_act;
      s1_wr  <= n_wr;
      s1_a   <= n_addr;
      s1_m   <= byte_sel;
      s2_v   <= s1_v;
      s2_wr  <= s1_wr;
      s2_a   <= s1_a;
      s2_m   <= s1_m;
      oe_r   <= s2_v && !s2_wr;
      if (s2_v && !s2_wr) data_out <= mem[s2_a];
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst_n && clk_en && s2_v && s2_wr && s2_m[i])
        mem[s2_a][i*BYTE_W +: BYTE_W] <= data_in[i*BYTE_W +: BYTE_W];
    end
  end

  assign data_oe = oe_r && oe;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(data_out) && $stable(oe_r) && $stable(s2_v))); // R3
  AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s2_v && s2_wr) |=> !oe_r); // R6
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !s2_v) |=> !oe_r); // R5
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv) |=> (b_cnt == $past(b_cnt) + 2'd1)); // R7
  AST_DESEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv && !b_act) |=> !s1_v); // R9

endmodule

// File: tb/pipe_sram_tb.sv
module pipe_sram_tb_top;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic clk = 0, rst_n = 0, clk_en = 0, ce_a_n = 1, ce_b = 0, ce_c_n = 1;
  logic adv = 0, wr_en = 0, burst_lin = 0, oe = 1;
  logic [NB-1:0] byte_sel = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out;
  logic data_oe;

  pipe_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce_a_n(ce_a_n), .ce_b(ce_b),
    .ce_c_n(ce_c_n), .adv(adv), .wr_en(wr_en), .byte_sel(byte_sel), .addr(addr),
    .burst_lin(burst_lin), .oe(oe), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [1 << AW];
  logic m_act = 0, m_wr = 0, m_lin = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;
  logic p1v = 0, p1w = 0, p2v = 0, p2w = 0;
  logic [AW-1:0] p1a = '0, p2a = '0;
  logic [NB-1:0] p1m = '0, p2m = '0;
  logic [DW-1:0] p1d = '0, p2d = '0;
  logic [DW-1:0] exp_out = '0;
  logic exp_oe = 0;

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic ce, input logic a, input logic w,
                      input logic [AW-1:0] ad, input logic [NB-1:0] bs,
                      input logic lin, input logic [2:0] sel, input logic [DW-1:0] wd);
    logic n_act, n_wr, n_lin;
    logic [AW-1:0] n_base, n_addr;
    logic [1:0] n_cnt, n_low;
    clk_en = ce; adv = a; wr_en = w; addr = ad; byte_sel = bs; burst_lin = lin;
    ce_a_n = !sel[0]; ce_b = sel[1]; ce_c_n = !sel[2];
    data_in = (p2v && p2w) ? p2d : rnd_word();
    @(posedge clk);
    if (ce) begin
      n_act  = a ? m_act : (&sel);
      n_wr   = a ? m_wr : w;
      n_lin  = a ? m_lin : lin;
      n_base = a ? m_base : ad;
      n_cnt  = a ? m_cnt + 2'd1 : 2'd0;
      n_low  = n_lin ? n_base[1:0] + n_cnt : n_base[1:0] ^ n_cnt;
      n_addr = {n_base[AW-1:2], n_low};
      if (p2v && p2w)
        for (int i = 0; i < NB; i++)
          if (p2m[i]) ref_mem[p2a][i*BW +: BW] = p2d[i*BW +: BW];
      if (p2v && !p2w) exp_out = ref_mem[p2a];
      exp_oe = p2v && !p2w;
      p2v = p1v; p2w = p1w; p2a = p1a; p2m = p1m; p2d = p1d;
      p1v = n_act; p1w = n_wr; p1a = n_addr; p1m = bs; p1d = wd;
      m_act = n_act; m_wr = n_wr; m_lin = n_lin; m_base = n_base; m_cnt = n_cnt;
    end
    @(negedge clk);
    check({tag, " data_out"}, data_out, exp_out);
    check({tag, " data_oe"}, DW'(data_oe), DW'(exp_oe && oe));
  endtask

  task automatic wr(input string t, input logic [AW-1:0] a, input logic [NB-1:0] m, input logic [DW-1:0] d);
    step(t, 1, 0, 1, a, m, 1, 3'b111, d);
  endtask
  task automatic rd(input string t, input logic [AW-1:0] a);
    step(t, 1, 0, 0, a, '1, 1, 3'b111, '0);
  endtask
  task automatic idle(input string t, input int n);
    for (int i = 0; i < n; i++) step(t, 1, 0, 0, '0, '0, 1, 3'b000, '0);
  endtask

  task automatic t_reset();
    check("R11 reset data_out", data_out, '0);
    check("R11 reset data_oe", DW'(data_oe), '0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < (1 << AW); a++) wr("R2 fill", AW'(a), '1, rnd_word());
    idle("R2 flush", 2);
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 16; i++) begin
      wr("R2 alt write", AW'(i), '1, rnd_word());
      rd("R10 read after write", AW'(i));
    end
    rd("R1 read latency", 6'd3);
    idle("R1 drain", 2);
  endtask

  task automatic t_bytes();
    wr("R4 full", 6'd20, '1, '0);
    wr("R4 byte0", 6'd20, 4'b0001, {DW{1'b1}});
    wr("R4 byte2", 6'd20, 4'b0100, {DW{1'b1}});
    rd("R4 merged read", 6'd20);
    wr("R4 no bytes", 6'd20, 4'b0000, rnd_word());
    rd("R4 masked-out write", 6'd20);
    idle("R4 drain", 2);
  endtask

  task automatic t_stall();
    wr("R3 stall write", 6'd9, '1, rnd_word());
    rd("R3 stall read", 6'd9);
    wr("R3 stall write2", 6'd9, 4'b1010, rnd_word());
    for (int i = 0; i < 3; i++) step("R3 held", 0, 0, 1, 6'd9, '1, 1, 3'b111, rnd_word());
    rd("R3 after stall", 6'd9);
    step("R3 held read", 0, 1, 0, '0, '0, 1, 3'b000, '0);
    idle("R3 drain", 3);
  endtask

  task automatic t_deselect();
    for (int s = 0; s < 7; s++) begin
      step("R5 deselected write", 1, 0, 1, 6'd30, '1, 1, 3'(s), rnd_word());
      step("R9 advance deselected", 1, 1, 0, '0, '1, 1, 3'b111, rnd_word());
      step("R5 deselected read", 1, 0, 0, 6'd30, '1, 1, 3'(s), '0);
    end
    rd("R5 unchanged", 6'd30);
    rd("R5 unchanged2", 6'd31);
    idle("R5 drain", 2);
  endtask

  task automatic t_oe();
    rd("R6 read", 6'd5);
    idle("R6 wait", 1);
    step("R6 pending", 1, 0, 0, '0, '0, 1, 3'b000, '0);
    oe = 0; #0.5;
    check("R6 oe low", DW'(data_oe), '0);
    oe = 1; #0.5;
    check("R6 oe high", DW'(data_oe), DW'(exp_oe));
    wr("R6 write slot", 6'd6, '1, rnd_word());
    idle("R6 write data", 2);
  endtask

  task automatic t_burst(input string t, input logic lin);
    for (int b = 0; b < 4; b++) begin
      step(t, 1, 0, 1, AW'(40 + b), '1, lin, 3'b111, rnd_word());
      for (int k = 0; k < 3; k++) step(t, 1, 1, 0, '0, '1, 0, 3'b000, rnd_word());
      step(t, 1, 0, 0, AW'(40 + b), '1, lin, 3'b111, '0);
      for (int k = 0; k < 3; k++) step(t, 1, 1, 0, '0, '1, 0, 3'b000, '0);
      for (int k = 0; k < 4; k++) rd(t, AW'(40 + k));
    end
    idle(t, 2);
  endtask

  task automatic t_random();
    for (int i = 0; i < 600; i++)
      step("R2 random mix", ($urandom % 8) != 0, ($urandom % 3) == 0, $urandom % 2,
           AW'($urandom), NB'($urandom), $urandom % 2,
           (($urandom % 6) == 0) ? 3'($urandom) : 3'b111, rnd_word());
    idle("R2 random drain", 3);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_alternate();
    t_bytes();
    t_stall();
    t_deselect();
    t_oe();
    t_burst("R7 linear burst", 1);
    t_burst("R8 interleaved burst", 0);
    t_random();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule